// File: doc/BRIEF.md
# Multi-Source Trigger Merger

This block takes three independent trigger sources and turns them into one level-zero trigger. That trigger is copied onto a wide bank of identical, synchronously registered outputs, one pair for each digitizer.

The three sources are:
- **Beam-bunch trigger.** It is postponed by a programmable number of clock cycles, so the trigger can be lined up with the arrival of the particles.
- **Cosmic-ray trigger.** It is the coincidence of two counter stations. Each station is the OR of its finger counters.
- **Pedestal trigger.** It comes from software or a random source. It is accepted only in the quiet time between bunches, and only when no other source is active.

All inputs are asynchronous. Each one is brought into the system clock domain and turned into a single-cycle event.

The merged trigger is stretched to a programmable width. A dead time follows it, and during the dead time further candidates are dropped. A per-source enable mask selects which sources take part. Each accepted trigger leaves two records: a tag showing which sources caused it, and a running count.

Top module: `trigger_merger`

## Requirements
- R1: While `rst` is high and after it is released, `trig_out`, `src_tag` and `trig_count` are all zero until the first accepted trigger.
- R2: Let edge 1 be the first clock edge that samples `beam_in` high. With `beam_delay` = D, `trig_out` goes high after edge D+3. This covers two synchronizer stages plus one output register.
- R3: A second beam event that is detected while a beam delay is still counting is ignored. It neither restarts nor adds to the count.
- R4: A cosmic trigger needs at least one finger high in station A and at least one finger high in station B at the same time. Activity in one station alone never triggers. The output goes high after the third edge that samples the coincidence.
- R5: A pedestal event is dropped in any cycle in which a beam event is detected, a beam delay is running, or a cosmic coincidence event occurs. Otherwise it triggers with the same 3-edge latency.
- R6: `src_mask` enables the sources: bit 0 is beam, bit 1 is cosmic, bit 2 is pedestal. A source whose bit is 0 produces no trigger.
- R7: Each trigger keeps `trig_out` high for `pulse_width` cycles. A width of 0 is treated as 1.
- R8: After the output falls, candidates are dropped for `dead_time` cycles. A candidate in the cycle right after that window is accepted. This gives a minimum low gap of `dead_time`+1 cycles.
- R9: All FANOUT bits of `trig_out` are identical on every cycle.
- R10: `src_tag` is loaded on the edge where the output rises and holds its value until the next trigger. Its bits are {pedestal, cosmic, beam} at positions 2..0. Sources that arrive together set several bits.
- R11: `trig_count` goes up by one for each accepted trigger and wraps modulo 2^CNT_W.
- R12: An input held high for many cycles produces only one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_in | input | 1 | Asynchronous bunch-arrival signal |
| ped_in | input | 1 | Asynchronous software/random pedestal request |
| fingers_a | input | FINGERS | Asynchronous finger counters of cosmic station A |
| fingers_b | input | FINGERS | Asynchronous finger counters of cosmic station B |
| src_mask | input | 3 | Source enables {pedestal, cosmic, beam} |
| beam_delay | input | DELAY_W | Beam trigger delay in clock cycles |
| pulse_width | input | WIDTH_W | Output pulse width in cycles (0 acts as 1) |
| dead_time | input | DEAD_W | Blocking window after each pulse, in cycles |
| trig_out | output | FANOUT | Registered, identical trigger copies |
| src_tag | output | 3 | Sources of the last accepted trigger |
| trig_count | output | CNT_W | Accepted trigger counter |

## Verification
The bench keeps FANOUT at 64, FINGERS at 16 and the 16-bit delay field. It narrows CNT_W to 4, so the accepted-trigger counter wraps within the roughly seventeen triggers of the run.

Random beam delays of up to 40 cycles, together with random widths (0 included) and dead times, cover the delay and stretch arithmetic. Directed sequences place a second event exactly inside and exactly after the dead window. Other directed cases fire a pedestal while a delay is running, and fire all sources in the same cycle.

// File: rtl/trig_merge_pkg.sv
package trig_merge_pkg;

    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic ped;
        logic cos;
        logic beam;
    } src_vec_t;

    function automatic logic src_any(input src_vec_t v);
        return v.ped | v.cos | v.beam;
    endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/beam_delay.sv
module beam_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [DW-1:0] delay,
    output logic          fire,
    output logic          busy
);
    logic [DW-1:0] remain;

    assign busy = (remain != '0);
    assign fire = (evt && !busy && (delay == '0)) || (remain == DW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (busy)
            remain <= remain - 1'b1;
        else if (evt)
            remain <= delay;
    end

    // R3
    retrigger_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && evt) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/out_stage.sv
module out_stage
    import trig_merge_pkg::*;
#(
    parameter int FANOUT = 64,
    parameter int WW     = 8,
    parameter int DTW    = 8,
    parameter int CW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  src_vec_t          req,
    input  logic [WW-1:0]     width,
    input  logic [DTW-1:0]    dead,
    output logic [FANOUT-1:0] trig_out,
    output src_vec_t          tag,
    output logic [CW-1:0]     count
);
    logic           on_q;
    logic [WW-1:0]  rem;
    logic [DTW-1:0] dcnt;
    logic           blocked;
    logic           accept;
    logic           on_next;

    assign blocked = on_q || (dcnt != '0);
    assign accept  = !blocked && src_any(req);
    assign on_next = accept || (on_q && (rem != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            rem   <= '0;
            dcnt  <= '0;
            tag   <= '0;
            count <= '0;
        end else if (accept) begin
            on_q  <= 1'b1;
            rem   <= (width == '0) ? '0 : width - 1'b1;
            tag   <= req;
            count <= count + 1'b1;
        end else if (on_q) begin
            if (rem == '0) begin
                on_q <= 1'b0;
                dcnt <= dead;
            end else begin
                rem <= rem - 1'b1;
            end
        end else if (dcnt != '0) begin
            dcnt <= dcnt - 1'b1;
        end
    end

    for (genvar i = 0; i < FANOUT; i++) begin : g_fan
        always_ff @(posedge clk) begin
            if (rst) trig_out[i] <= 1'b0;
            else     trig_out[i] <= on_next;
        end
    end

    // R9
    fanout_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_out == '0) || (trig_out == '1));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_out[0]) |-> (count == $past(count) + 1'b1));

    // R8
    dead_block_chk: assert property (@(posedge clk) disable iff (rst)
        (dcnt != '0) |=> !$rose(trig_out[0]));
endmodule

// File: rtl/trigger_merger.sv
module trigger_merger
    import trig_merge_pkg::*;
#(
    parameter int FINGERS = 16,
    parameter int FANOUT  = 64,
    parameter int DELAY_W = 16,
    parameter int WIDTH_W = 8,
    parameter int DEAD_W  = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               beam_in,
    input  logic               ped_in,
    input  logic [FINGERS-1:0] fingers_a,
    input  logic [FINGERS-1:0] fingers_b,
    input  logic [2:0]         src_mask,
    input  logic [DELAY_W-1:0] beam_delay,
    input  logic [WIDTH_W-1:0] pulse_width,
    input  logic [DEAD_W-1:0]  dead_time,
    output logic [FANOUT-1:0]  trig_out,
    output logic [2:0]         src_tag,
    output logic [CNT_W-1:0]   trig_count
);
    localparam int ASYNC_W = 2 + 2 * FINGERS;

    logic [ASYNC_W-1:0] raw_in;
    logic [ASYNC_W-1:0] syn_in;
    logic               beam_s, ped_s, coinc_s;
    logic               beam_d, ped_d, coinc_d;
    logic               beam_evt, ped_evt, cos_evt;
    logic               beam_fire, beam_busy;
    src_vec_t           req;
    src_vec_t           tag_q;

    assign raw_in = {fingers_b, fingers_a, ped_in, beam_in};

    sync_2ff #(.W(ASYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign beam_s  = syn_in[0];
    assign ped_s   = syn_in[1];
    assign coinc_s = (|syn_in[2 +: FINGERS]) && (|syn_in[2 + FINGERS +: FINGERS]);

    always_ff @(posedge clk) begin
        if (rst) begin
            beam_d  <= 1'b0;
            ped_d   <= 1'b0;
            coinc_d <= 1'b0;
        end else begin
            beam_d  <= beam_s;
            ped_d   <= ped_s;
            coinc_d <= coinc_s;
        end
    end

    assign beam_evt = beam_s  && !beam_d;
    assign ped_evt  = ped_s   && !ped_d;
    assign cos_evt  = coinc_s && !coinc_d;

    beam_delay #(.DW(DELAY_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .evt   (beam_evt),
        .delay (beam_delay),
        .fire  (beam_fire),
        .busy  (beam_busy)
    );

    always_comb begin
        req.beam = beam_fire && src_mask[0];
        req.cos  = cos_evt   && src_mask[1];
        req.ped  = ped_evt   && src_mask[2] && !beam_evt && !beam_busy && !cos_evt;
    end

    out_stage #(
        .FANOUT (FANOUT),
        .WW     (WIDTH_W),
        .DTW    (DEAD_W),
        .CW     (CNT_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .width    (pulse_width),
        .dead     (dead_time),
        .trig_out (trig_out),
        .tag      (tag_q),
        .count    (trig_count)
    );

    assign src_tag = tag_q;

    // R5
    ped_alone_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(trig_out[0]) && src_tag[2]) |-> (src_tag[1:0] == 2'b00));

    // R6
    mask_respected_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_out[0]) |-> ((src_tag & ~$past(src_mask)) == 3'b000));
endmodule

// File: tb/trigger_merger_tb.sv
module trigger_merger_tb;
    localparam int FING = 16;
    localparam int FAN  = 64;
    localparam int DW   = 16;
    localparam int WW   = 8;
    localparam int DTW  = 8;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            beam_in = 1'b0;
    logic            ped_in = 1'b0;
    logic [FING-1:0] fingers_a = '0;
    logic [FING-1:0] fingers_b = '0;
    logic [2:0]      src_mask = 3'b111;
    logic [DW-1:0]   beam_delay = '0;
    logic [WW-1:0]   pulse_width = 8'd1;
    logic [DTW-1:0]  dead_time = '0;
    logic [FAN-1:0]  trig_out;
    logic [2:0]      src_tag;
    logic [CW-1:0]   trig_count;

    trigger_merger #(
        .FINGERS(FING), .FANOUT(FAN), .DELAY_W(DW),
        .WIDTH_W(WW), .DEAD_W(DTW), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst(rst), .beam_in(beam_in), .ped_in(ped_in),
        .fingers_a(fingers_a), .fingers_b(fingers_b), .src_mask(src_mask),
        .beam_delay(beam_delay), .pulse_width(pulse_width), .dead_time(dead_time),
        .trig_out(trig_out), .src_tag(src_tag), .trig_count(trig_count)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rises = 0;
    int rise_cyc = 0;
    int cur_w = 0;
    int last_w = 0;
    int split_bad = 0;
    bit prev_o = 1'b0;
    bit done = 1'b0;
    logic [CW-1:0] exp_count = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (trig_out != '0 && trig_out != '1) split_bad++;
            if (trig_out[0] && !prev_o) begin
                rises++;
                rise_cyc = cyc;
                cur_w = 1;
            end else if (trig_out[0]) begin
                cur_w++;
            end else if (prev_o) begin
                last_w = cur_w;
            end
            prev_o = trig_out[0];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int exp_lat(input int d);
        return d + 3;
    endfunction

    function automatic int exp_width(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic fire_beam();
        beam_in = 1'b1; tick(2); beam_in = 1'b0;
    endtask

    task automatic fire_ped();
        ped_in = 1'b1; tick(2); ped_in = 1'b0;
    endtask

    task automatic expect_one(input string req, input int base_r, input int k,
                              input int lat, input int w, input int tag);
        chk(rises == base_r + 1, req, "rise count", rises - base_r, 1);
        chk(rise_cyc - k == lat, req, "latency", rise_cyc - k, lat);
        chk(last_w == w, "R7", "pulse width", last_w, w);
        chk(int'(src_tag) == tag, "R10", "source tag", src_tag, tag);
        exp_count = exp_count + 1'b1;
        chk(trig_count == exp_count, "R11", "trigger count", trig_count, exp_count);
    endtask

    task automatic expect_none(input string req, input int base_r);
        chk(rises == base_r, req, "unexpected trigger", rises - base_r, 0);
        chk(trig_count == exp_count, req, "count unchanged", trig_count, exp_count);
    endtask

    initial begin
        int k;
        int base_r;
        int first_rise;
        int d, w, dd;
        void'($urandom(32'd1234));

        // R1: reset state
        tick(3);
        chk(trig_out == '0, "R1", "trig_out in reset", int'(trig_out[0]), 0);
        chk(src_tag == 3'b000, "R1", "tag in reset", src_tag, 0);
        chk(trig_count == '0, "R1", "count in reset", trig_count, 0);
        rst = 1'b0;
        tick(3);
        chk(trig_out == '0 && trig_count == '0, "R1", "idle after reset", trig_count, 0);

        // R2: zero delay beam
        beam_delay = 0; pulse_width = 3; dead_time = 2;
        base_r = rises; k = cyc;
        fire_beam(); tick(15);
        expect_one("R2", base_r, k, exp_lat(0), 3, 1);

        // R2 random delays, widths and dead times
        for (int i = 0; i < 8; i++) begin
            d = $urandom_range(0, 40);
            w = $urandom_range(0, 9);
            dd = $urandom_range(0, 10);
            beam_delay = DW'(d); pulse_width = WW'(w); dead_time = DTW'(dd);
            base_r = rises; k = cyc;
            fire_beam(); tick(d + w + dd + 12);
            expect_one("R2", base_r, k, exp_lat(d), exp_width(w), 1);
        end

        // R3: retrigger during delay ignored
        beam_delay = 20; pulse_width = 2; dead_time = 2;
        base_r = rises; k = cyc;
        fire_beam(); tick(3); fire_beam(); tick(40);
        expect_one("R3", base_r, k, exp_lat(20), 2, 1);

        // R4: one station alone
        fingers_a = FING'($urandom_range(1, 16'hFFFF));
        base_r = rises;
        tick(12);
        expect_none("R4", base_r);
        // R4 + R12: coincidence held long gives one trigger
        base_r = rises; k = cyc;
        fingers_b = FING'(1) << $urandom_range(0, FING - 1);
        tick(10);
        fingers_a = '0; fingers_b = '0;
        tick(10);
        expect_one("R12", base_r, k, 3, 2, 2);

        // R5: pedestal alone
        base_r = rises; k = cyc;
        fire_ped(); tick(12);
        expect_one("R5", base_r, k, 3, 2, 4);

        // R5: pedestal while beam delay runs is dropped
        beam_delay = 15;
        base_r = rises; k = cyc;
        fire_beam(); tick(2); fire_ped(); tick(30);
        expect_one("R5", base_r, k, exp_lat(15), 2, 1);

        // R10: simultaneous sources, pedestal suppressed
        beam_delay = 0;
        base_r = rises; k = cyc;
        beam_in = 1; ped_in = 1; fingers_a = 16'h0010; fingers_b = 16'h0400;
        tick(2);
        beam_in = 0; ped_in = 0; fingers_a = '0; fingers_b = '0;
        tick(12);
        expect_one("R10", base_r, k, 3, 2, 3);

        // R6: masked sources
        src_mask = 3'b110;
        base_r = rises;
        fire_beam(); tick(12);
        expect_none("R6", base_r);
        src_mask = 3'b011;
        base_r = rises;
        fire_ped(); tick(12);
        expect_none("R6", base_r);
        src_mask = 3'b101;
        base_r = rises;
        fingers_a = 16'h0001; fingers_b = 16'h8000; tick(2);
        fingers_a = '0; fingers_b = '0; tick(12);
        expect_none("R6", base_r);
        src_mask = 3'b111;

        // R8: dead time, inside and first-allowed boundary
        pulse_width = 2; dead_time = 5;
        base_r = rises; k = cyc;
        fingers_a = 16'h0001; fingers_b = 16'h8000; tick(2);
        fingers_a = '0; fingers_b = '0; tick(2);
        fingers_a = 16'h0001; fingers_b = 16'h8000; tick(2);
        fingers_a = '0; fingers_b = '0; tick(2);
        expect_one("R8", base_r, k, 3, 2, 2);
        first_rise = rise_cyc;
        fingers_a = 16'h0001; fingers_b = 16'h8000; tick(2);
        fingers_a = '0; fingers_b = '0; tick(20);
        chk(rises == base_r + 2, "R8", "two triggers only", rises - base_r, 2);
        chk(rise_cyc == k + 11, "R8", "boundary accept cycle", rise_cyc - k, 11);
        chk(rise_cyc - (first_rise + 2) == 6, "R8", "low gap", rise_cyc - first_rise - 2, 6);
        exp_count = exp_count + 1'b1;
        chk(trig_count == exp_count, "R11", "count after wrap", trig_count, exp_count);

        // R7: zero width acts as one
        pulse_width = 0; dead_time = 0; beam_delay = 4;
        base_r = rises; k = cyc;
        fire_beam(); tick(15);
        expect_one("R7", base_r, k, exp_lat(4), 1, 1);

        // R9: fan-out identical throughout
        chk(split_bad == 0, "R9", "fan-out mismatch cycles", split_bad, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule